// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns a segment reference and an offset into the address that goes to memory. A request names one of six segment registers, carries the 16-bit value held in that register, and carries a 64-bit offset. The block then produces the address one clock later. It has two modes, chosen for each request.

In legacy real mode the base is the segment value shifted left by four bits. Only the low 16 bits of the offset are added to it. The sum is kept to 20 bits, so it wraps past the 1 MiB boundary, and no limit check is made. In 64-bit flat mode the four legacy segments have a base of zero. The two extra segments (codes 4 and 5) add a 64-bit base that software loads through a small write port. The addition wraps modulo 2^64.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, `addr_valid` is 0, `addr_out` is 0, and both extra-segment base registers hold 0.
- R2: `addr_valid` equals `req_valid` from the previous cycle. When `req_valid` was 0, `addr_out` keeps its previous value.
- R3: In real mode (`mode_long`=0), `addr_out` = (`seg_value`*16 + `offset[15:0]`) mod 2^20. Bits 63:20 are zero and bits 3:0 equal `offset[3:0]`.
- R4: In real mode, `offset[63:16]`, `seg_id` and both base registers have no effect on `addr_out`.
- R5: A real-mode sum above 0xFFFFF wraps to the bottom of the space. Segment 0xFFFF with offset 0x0010 gives 0x00000, and segment 0xFFFF with offset 0xFFFF gives 0x0FFEF.
- R6: In 64-bit mode, `seg_id` codes 0..3 (ES, CS, SS, DS) and the unused codes 6 and 7 give `addr_out` = `offset`. `seg_value` is ignored.
- R7: In 64-bit mode, `seg_id` 4 adds the first base register (FS) and `seg_id` 5 adds the second (GS). In both cases `addr_out` = base + `offset` mod 2^64, so the sum wraps past 2^64-1.
- R8: When `base_wr_en` is 1, the rising edge stores `base_wr_data` into the FS base (`base_wr_sel`=0) or the GS base (`base_wr_sel`=1). A request in the same cycle uses the old base. Requests from the next cycle on use the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| mode_long | input | 1 | 1 selects 64-bit flat mode, 0 selects real mode |
| seg_id | input | 3 | Segment code: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS |
| seg_value | input | 16 | Contents of the named segment register (used in real mode) |
| offset | input | 64 | Offset to add to the segment base |
| base_wr_en | input | 1 | Write strobe for the extra-segment bases |
| base_wr_sel | input | 1 | 0 writes the FS base, 1 writes the GS base |
| base_wr_data | input | 64 | Value for the selected base register |
| addr_out | output | 64 | Computed address, registered |
| addr_valid | output | 1 | `addr_out` carries a new result |

## Verification
The inline assertions check these properties on every cycle:
- the one-cycle valid latency, and that the address holds when there is no request;
- in real mode, zero upper bits and the low nibble passed through unchanged;
- in 64-bit mode, the identity mapping of the legacy segments.

Other behaviour shows only in the bench scenarios. These cover:
- the exact real-mode sums at both wrap points;
- the 64-bit carry-out wrap with a programmed base;
- the one-cycle timing of base writes against a request in the same cycle;
- insensitivity to the high offset bits and to the base registers in real mode.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int OFS_W      = 64,
  parameter int SEG_W      = 16,
  parameter int SEG_SHIFT  = 4,
  parameter int REAL_OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             mode_long,
  input  logic [2:0]       seg_id,
  input  logic [SEG_W-1:0] seg_value,
  input  logic [OFS_W-1:0] offset,
  input  logic             base_wr_en,
  input  logic             base_wr_sel,
  input  logic [OFS_W-1:0] base_wr_data,
  output logic [OFS_W-1:0] addr_out,
  output logic             addr_valid
);
  localparam int REAL_W = SEG_W + SEG_SHIFT;
  localparam logic [2:0] ID_FS = 3'd4;
  localparam logic [2:0] ID_GS = 3'd5;

  logic [OFS_W-1:0]  fs_base, gs_base, long_base, long_sum, next_addr;
  logic [REAL_W-1:0] real_sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_base <= '0;
      gs_base <= '0;
    end else if (base_wr_en) begin
      if (base_wr_sel) gs_base <= base_wr_data;
      else             fs_base <= base_wr_data;
    end
  end

  assign real_sum  = {seg_value, {SEG_SHIFT{1'b0}}} + REAL_W'(offset[REAL_OFS_W-1:0]);
  assign long_base = (seg_id == ID_FS) ? fs_base :
                     (seg_id == ID_GS) ? gs_base : '0;
  assign long_sum  = long_base + offset;
  assign next_addr = mode_long ? long_sum : OFS_W'(real_sum);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_out   <= '0;
      addr_valid <= 1'b0;
    end else begin
      addr_valid <= req_valid;
      if (req_valid) addr_out <= next_addr;
    end
  end

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> addr_valid == $past(req_valid));

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(req_valid)) |-> $stable(addr_out));

  a_r3_real_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && addr_valid && !$past(mode_long)) |-> addr_out[OFS_W-1:REAL_W] == '0);

  a_r3_real_low_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && addr_valid && !$past(mode_long))
      |-> addr_out[SEG_SHIFT-1:0] == $past(offset[SEG_SHIFT-1:0]));

  a_r6_flat_identity: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && addr_valid && $past(mode_long) &&
     $past(seg_id) != ID_FS && $past(seg_id) != ID_GS) |-> addr_out == $past(offset));
endmodule

// File: tb/tb_seg_addr_gen.sv
module tb_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, mode_long = 1'b0;
  logic [2:0]  seg_id = '0;
  logic [15:0] seg_value = '0;
  logic [63:0] offset = '0;
  logic        base_wr_en = 1'b0, base_wr_sel = 1'b0;
  logic [63:0] base_wr_data = '0;
  logic [63:0] addr_out;
  logic        addr_valid;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  seg_addr_gen dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode_long(mode_long),
    .seg_id(seg_id), .seg_value(seg_value), .offset(offset), .base_wr_en(base_wr_en),
    .base_wr_sel(base_wr_sel), .base_wr_data(base_wr_data), .addr_out(addr_out),
    .addr_valid(addr_valid));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] real_ref(input logic [15:0] s, input logic [63:0] o);
    logic [63:0] t;
    t = ({48'd0, s} * 64'd16) + {48'd0, o[15:0]};
    return t & 64'h0000_0000_000F_FFFF;
  endfunction

  task automatic issue(input logic m, input logic [2:0] id, input logic [15:0] s,
                       input logic [63:0] o);
    @(negedge clk);
    req_valid = 1'b1; mode_long = m; seg_id = id; seg_value = s; offset = o;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic write_base(input logic sel, input logic [63:0] d);
    @(negedge clk);
    base_wr_en = 1'b1; base_wr_sel = sel; base_wr_data = d;
    @(negedge clk);
    base_wr_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 valid", {63'd0, addr_valid}, 64'd0);
    check("R1 addr", addr_out, 64'd0);
    issue(1'b1, 3'd4, 16'h0, 64'h1234);
    check("R1 fs base zero", addr_out, 64'h1234);
    issue(1'b1, 3'd5, 16'h0, 64'h5678);
    check("R1 gs base zero", addr_out, 64'h5678);
  endtask

  task automatic t_real;
    issue(1'b0, 3'd3, 16'h1234, 64'h0000_0000_0000_5678);
    check("R3 valid", {63'd0, addr_valid}, 64'd1);
    check("R3 sum", addr_out, real_ref(16'h1234, 64'h5678));
    issue(1'b0, 3'd1, 16'hA000, 64'h0000_0000_0000_0FFF);
    check("R3 sum2", addr_out, 64'hA0FFF);
    issue(1'b0, 3'd0, 16'h0001, 64'hDEAD_BEEF_CAFE_0003);
    check("R4 high offset ignored", addr_out, 64'h00013);
  endtask

  task automatic t_wrap;
    issue(1'b0, 3'd2, 16'hFFFF, 64'h10);
    check("R5 wrap to zero", addr_out, 64'h0);
    issue(1'b0, 3'd2, 16'hFFFF, 64'hFFFF);
    check("R5 wrap top", addr_out, 64'h0FFEF);
  endtask

  task automatic t_hold;
    logic [63:0] prev;
    prev = addr_out;
    @(negedge clk);
    mode_long = 1'b1; seg_id = 3'd0; offset = 64'hFFFF_0000_1111_2222;
    @(negedge clk);
    check("R2 idle valid", {63'd0, addr_valid}, 64'd0);
    check("R2 hold", addr_out, prev);
  endtask

  task automatic t_flat;
    for (int i = 0; i < 8; i++) begin
      if (i == 4 || i == 5) continue;
      issue(1'b1, 3'(i), 16'hBEEF, 64'h8000_0000_0000_0000 + 64'(i));
      check("R6 flat identity", addr_out, 64'h8000_0000_0000_0000 + 64'(i));
    end
  endtask

  task automatic t_fsgs;
    write_base(1'b0, 64'h0000_7000_0000_0000);
    write_base(1'b1, 64'hFFFF_FFFF_FFFF_FF00);
    issue(1'b1, 3'd4, 16'h0, 64'h42);
    check("R7 fs add", addr_out, 64'h0000_7000_0000_0042);
    issue(1'b1, 3'd5, 16'h0, 64'h10);
    check("R7 gs add", addr_out, 64'hFFFF_FFFF_FFFF_FF10);
    issue(1'b1, 3'd5, 16'h0, 64'h180);
    check("R7 gs wrap 2^64", addr_out, 64'h80);
    issue(1'b0, 3'd4, 16'h0100, 64'h5);
    check("R4 real ignores fs base", addr_out, 64'h01005);
  endtask

  task automatic t_wr_timing;
    @(negedge clk);
    base_wr_en = 1'b1; base_wr_sel = 1'b0; base_wr_data = 64'h1000;
    req_valid = 1'b1; mode_long = 1'b1; seg_id = 3'd4; offset = 64'h1;
    @(negedge clk);
    base_wr_en = 1'b0;
    check("R8 same-cycle uses old", addr_out, 64'h0000_7000_0000_0001);
    req_valid = 1'b1; offset = 64'h2;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 next uses new", addr_out, 64'h1002);
    issue(1'b1, 3'd5, 16'h0, 64'h100);
    check("R8 gs untouched", addr_out, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_real();
    t_wrap();
    t_hold();
    t_flat();
    t_fsgs();
    t_wr_timing();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule